// File: doc/BRIEF.md
# DRAM Rank Command Decoder

This block watches the control and address pins of one DDR3 rank and turns each sampled cycle into a decoded operation. On every rising clock edge it reads clock enable, chip select, the three active-low strobes, a bank index and a sixteen-bit address word. One cycle later it presents a registered result: a valid pulse with the operation type, the bank, the address field, an all-banks flag, an auto-precharge flag, a chopped-burst flag, and the row currently held open in the addressed bank.

Alongside decoding, the block keeps an open flag and a latched row for each of the eight banks. It closes banks on explicit precharge and also after a timed auto-precharge. It raises a one-cycle protocol error when a command breaks the open/closed rules. A monitor or memory model can place it next to a controller to follow bank state and catch illegal traffic.

Top module: `dram_cmd_decode`

## Requirements
- R1: A cycle with clock enable high and chip select low is decoded from (ras_n, cas_n, we_n): 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 ZQ calibration, 111 no-operation. For every decoded operation except no-operation, `out_valid` is high after the next edge with `out_op` coded 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set, 7 ZQ, plus `out_bank`=ba and `out_addr`=addr. In all other cycles `out_valid` is low and all command fields read zero.
- R2: While chip select is high, the sampled command has no effect: there is no valid pulse, no error, and no change to `open_banks`. Pending auto-precharge timers keep running.
- R3: An activate to a closed bank sets that bank's bit in `open_banks` and stores addr as the bank's open row.
- R4: On read or write, `out_chop` is the inverse of addr bit 12 (1 means a chopped burst of 4, 0 a full burst of 8), and `out_row` holds the stored row of the addressed bank. On all other operations `out_row` is zero.
- R5: On a legal read or write with addr bit 10 high, `out_auto_pre` is 1. The bank's `open_banks` bit then clears at the edge AP_FULL (default 4) cycles after the command edge for a full burst, or AP_CHOP (default 2) cycles after it for a chopped burst.
- R6: A precharge with addr bit 10 high closes all banks, whatever ba is, and sets `out_all_banks`. With bit 10 low it closes only bank ba and leaves `out_all_banks` at 0.
- R7: With clock enable sampled low, nothing is decoded. On the first low sample after a high sample, `out_sr_enter` pulses if chip select is low with strobes 001; otherwise `out_pd_enter` pulses.
- R8: A read or write to a closed bank, or an activate to an open bank, gives `proto_err` for one cycle and leaves bank state unchanged.
- R9: A refresh or a mode-register set while any bank is open gives `proto_err` for one cycle.
- R10: After synchronous reset, all outputs are zero and all banks are closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 3 | Bank index |
| addr | input | 16 | Row/column address word |
| out_valid | output | 1 | Decoded operation pulse |
| out_op | output | 3 | Operation code |
| out_bank | output | 3 | Bank of the operation |
| out_all_banks | output | 1 | Precharge covers every bank |
| out_addr | output | 16 | Row or column address |
| out_auto_pre | output | 1 | Read/write with auto-precharge |
| out_chop | output | 1 | Chopped burst of 4 |
| out_row | output | 16 | Open row of addressed bank on read/write |
| out_pd_enter | output | 1 | Power-down entry pulse |
| out_sr_enter | output | 1 | Self-refresh entry pulse |
| proto_err | output | 1 | Illegal-sequence pulse |
| open_banks | output | 8 | Per-bank open flags |

## Verification
Bank state lives inside the block, so a corrupt open flag shows in `open_banks` one cycle after the edge that corrupted it. The next command to that bank then shows it again, as a wrong `proto_err` or as a stale `out_row`. A timer that is off by one shows as the bank bit clearing one cycle early or late, so the bench compares `open_banks` on every cycle of each auto-precharge window. A stored row that is wrong appears only once a later read or write names that bank.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_MRS = 3'd6,
    OP_ZQ  = 3'd7
  } op_e;

  // strobes are given in (ras_n, cas_n, we_n) order
  function automatic op_e strobe_to_op(input logic [2:0] strb);
    case (strb)
      3'b011:  return OP_ACT;
      3'b101:  return OP_RD;
      3'b100:  return OP_WR;
      3'b010:  return OP_PRE;
      3'b001:  return OP_REF;
      3'b000:  return OP_MRS;
      3'b110:  return OP_ZQ;
      default: return OP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/dcd_classify.sv
module dcd_classify
  import dcd_pkg::*;
(
  input  logic       cke,
  input  logic       cke_q,
  input  logic       cs_n,
  input  logic [2:0] strb,
  output logic       live,
  output op_e        op,
  output logic       pd_entry,
  output logic       sr_entry
);
  logic entry;

  always_comb begin
    live     = cke & ~cs_n;
    op       = live ? strobe_to_op(strb) : OP_NOP;
    entry    = ~cke & cke_q;
    sr_entry = entry & ~cs_n & (strb == 3'b001);
    pd_entry = entry & ~sr_entry;
  end
endmodule

// File: rtl/dcd_bank_slot.sv
module dcd_bank_slot
  import dcd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TMR_W   = 3,
  parameter int AP_FULL = 4,
  parameter int AP_CHOP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  op_e               op,
  input  logic              hit,
  input  logic              ap_bit,
  input  logic              full_bit,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_open,
  output logic [ADDR_W-1:0] row
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row     <= '0;
      tmr_q   <= '0;
    end else begin
      // the timer runs first, so a command on the same edge wins
      if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
        if (tmr_q == TMR_W'(1)) is_open <= 1'b0;
      end
      if (accept) begin
        case (op)
          OP_ACT: if (hit) begin
            is_open <= 1'b1;
            row     <= addr;
          end
          OP_RD, OP_WR: if (hit && ap_bit) begin
            is_open <= 1'b1;
            tmr_q   <= full_bit ? TMR_W'(AP_FULL) : TMR_W'(AP_CHOP);
          end
          OP_PRE: if (hit || ap_bit) begin
            is_open <= 1'b0;
            tmr_q   <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcd_bank_tracker.sv
module dcd_bank_tracker
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int AP_FULL   = 4,
  parameter int AP_CHOP   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int AP_MAX   = (AP_FULL > AP_CHOP) ? AP_FULL : AP_CHOP,
  localparam int TMR_W    = $clog2(AP_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 live,
  input  op_e                  op,
  input  logic [BA_W-1:0]      bank,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 ap_bit,
  input  logic                 full_bit,
  output logic [NUM_BANKS-1:0] open_mask,
  output logic [ADDR_W-1:0]    sel_row,
  output logic                 viol
);
  logic [ADDR_W-1:0] rows [NUM_BANKS];
  logic              accept;

  always_comb begin
    viol = 1'b0;
    if (live) begin
      case (op)
        OP_ACT:         viol = open_mask[bank];
        OP_RD, OP_WR:   viol = ~open_mask[bank];
        OP_REF, OP_MRS: viol = |open_mask;
        default:        viol = 1'b0;
      endcase
    end
    accept  = live & ~viol;
    sel_row = rows[bank];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dcd_bank_slot #(
      .ADDR_W (ADDR_W),
      .TMR_W  (TMR_W),
      .AP_FULL(AP_FULL),
      .AP_CHOP(AP_CHOP)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .accept  (accept),
      .op      (op),
      .hit     (bank == BA_W'(b)),
      .ap_bit  (ap_bit),
      .full_bit(full_bit),
      .addr    (addr),
      .is_open (open_mask[b]),
      .row     (rows[b])
    );
  end
endmodule

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int AP_BIT    = 10,
  parameter int CHOP_BIT  = 12,
  parameter int AP_FULL   = 4,
  parameter int AP_CHOP   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 out_valid,
  output logic [2:0]           out_op,
  output logic [BA_W-1:0]      out_bank,
  output logic                 out_all_banks,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_auto_pre,
  output logic                 out_chop,
  output logic [ADDR_W-1:0]    out_row,
  output logic                 out_pd_enter,
  output logic                 out_sr_enter,
  output logic                 proto_err,
  output logic [NUM_BANKS-1:0] open_banks
);
  logic              cke_q;
  logic              live, pd_entry, sr_entry, viol, is_rw;
  op_e               op;
  logic [ADDR_W-1:0] sel_row;

  dcd_classify u_classify (
    .cke     (cke),
    .cke_q   (cke_q),
    .cs_n    (cs_n),
    .strb    ({ras_n, cas_n, we_n}),
    .live    (live),
    .op      (op),
    .pd_entry(pd_entry),
    .sr_entry(sr_entry)
  );

  dcd_bank_tracker #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .AP_FULL  (AP_FULL),
    .AP_CHOP  (AP_CHOP)
  ) u_tracker (
    .clk      (clk),
    .rst      (rst),
    .live     (live),
    .op       (op),
    .bank     (ba),
    .addr     (addr),
    .ap_bit   (addr[AP_BIT]),
    .full_bit (addr[CHOP_BIT]),
    .open_mask(open_banks),
    .sel_row  (sel_row),
    .viol     (viol)
  );

  assign is_rw = (op == OP_RD) || (op == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q         <= 1'b0;
      out_valid     <= 1'b0;
      out_op        <= OP_NOP;
      out_bank      <= '0;
      out_all_banks <= 1'b0;
      out_addr      <= '0;
      out_auto_pre  <= 1'b0;
      out_chop      <= 1'b0;
      out_row       <= '0;
      out_pd_enter  <= 1'b0;
      out_sr_enter  <= 1'b0;
      proto_err     <= 1'b0;
    end else begin
      cke_q         <= cke;
      out_pd_enter  <= pd_entry;
      out_sr_enter  <= sr_entry;
      proto_err     <= viol;
      out_valid     <= 1'b0;
      out_op        <= OP_NOP;
      out_bank      <= '0;
      out_all_banks <= 1'b0;
      out_addr      <= '0;
      out_auto_pre  <= 1'b0;
      out_chop      <= 1'b0;
      out_row       <= '0;
      if (op != OP_NOP) begin
        out_valid     <= 1'b1;
        out_op        <= op;
        out_bank      <= ba;
        out_addr      <= addr;
        out_all_banks <= (op == OP_PRE) && addr[AP_BIT];
        out_auto_pre  <= is_rw && addr[AP_BIT];
        out_chop      <= is_rw && !addr[CHOP_BIT];
        out_row       <= is_rw ? sel_row : '0;
      end
    end
  end
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic [ADDR_W-1:0]    addr,
  input logic                 out_valid,
  input logic                 out_all_banks,
  input logic [ADDR_W-1:0]    out_addr,
  input logic                 out_pd_enter,
  input logic                 out_sr_enter,
  input logic                 proto_err,
  input logic [NUM_BANKS-1:0] open_banks
);
  op_e  c_op;
  logic c_live;

  always_comb begin
    c_live = cke && !cs_n;
    c_op   = strobe_to_op({ras_n, cas_n, we_n});
  end

  a_r2_deselect_idle: assert property (@(posedge clk) disable iff (rst)
    (cke && cs_n) |=> (!out_valid && !proto_err));

  a_r7_cke_low_idle: assert property (@(posedge clk) disable iff (rst)
    !cke |=> !out_valid);

  a_r7_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_valid, out_pd_enter, out_sr_enter}));

  a_r3_act_opens: assert property (@(posedge clk) disable iff (rst)
    (c_live && c_op == OP_ACT && !open_banks[ba])
      |=> (open_banks[$past(ba)] && out_addr == $past(addr)));

  a_r8_closed_access: assert property (@(posedge clk) disable iff (rst)
    (c_live && (c_op == OP_RD || c_op == OP_WR) && !open_banks[ba]) |=> proto_err);

  a_r6_close_all: assert property (@(posedge clk) disable iff (rst)
    (c_live && c_op == OP_PRE && addr[AP_BIT]) |=> (open_banks == '0 && out_all_banks));

  a_r9_refresh_open: assert property (@(posedge clk) disable iff (rst)
    (c_live && (c_op == OP_REF || c_op == OP_MRS) && (|open_banks)) |=> proto_err);
endmodule

bind dram_cmd_decode dcd_checker #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_W   (ADDR_W),
  .AP_BIT   (AP_BIT)
) u_chk (.*);

// File: tb/dram_cmd_decode_bench.sv
module dram_cmd_decode_bench;
  localparam logic [2:0] E_ACT = 3'b011, E_RD = 3'b101, E_WR = 3'b100, E_PRE = 3'b010,
                         E_REF = 3'b001, E_MRS = 3'b000, E_ZQ = 3'b110, E_NOP = 3'b111;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [15:0] addr = '0;
  logic        out_valid, out_all_banks, out_auto_pre, out_chop;
  logic        out_pd_enter, out_sr_enter, proto_err;
  logic [2:0]  out_op, out_bank;
  logic [15:0] out_addr, out_row;
  logic [7:0]  open_banks;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_cmd_decode u_dram_cmd_decode (.*);

  typedef struct {
    logic [52:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference state, built from the requirements
  bit          m_open [8];
  logic [15:0] m_row  [8];
  int          m_tmr  [8];
  bit          m_cke_q = 0;

  function automatic logic [52:0] pack_dut();
    return {out_valid, out_op, out_bank, out_all_banks, out_addr, out_auto_pre,
            out_chop, out_row, out_pd_enter, out_sr_enter, proto_err, open_banks};
  endfunction

  function automatic logic [2:0] enc_to_code(input logic [2:0] e);
    case (e)
      E_ACT: return 3'd1;  E_RD:  return 3'd2;  E_WR: return 3'd3;
      E_PRE: return 3'd4;  E_REF: return 3'd5;  E_MRS: return 3'd6;
      E_ZQ:  return 3'd7;  default: return 3'd0;
    endcase
  endfunction

  task automatic cyc(input bit ck, input bit cs, input logic [2:0] cmd,
                     input logic [2:0] b, input logic [15:0] a, input string tag);
    bit live, viol, rw, entry, sr, pd;
    logic [2:0] code;
    logic [15:0] row_o;
    logic [7:0] omask;
    exp_t e;
    @(negedge clk);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = cmd; ba = b; addr = a;
    live  = ck && !cs;
    code  = live ? enc_to_code(cmd) : 3'd0;
    rw    = (code == 3'd2) || (code == 3'd3);
    viol  = 0;
    if (code == 3'd1) viol = m_open[b];
    if (rw) viol = !m_open[b];
    if (code == 3'd5 || code == 3'd6)
      foreach (m_open[i]) if (m_open[i]) viol = 1;
    entry = !ck && m_cke_q;
    sr    = entry && !cs && cmd == E_REF;
    pd    = entry && !sr;
    row_o = rw ? m_row[b] : 16'h0;
    for (int i = 0; i < 8; i++)
      if (m_tmr[i] != 0) begin
        m_tmr[i]--;
        if (m_tmr[i] == 0) m_open[i] = 0;
      end
    if (code != 0 && !viol) begin
      for (int i = 0; i < 8; i++) begin
        if (code == 3'd1 && i == int'(b)) begin m_open[i] = 1; m_row[i] = a; end
        if (rw && i == int'(b) && a[10]) begin m_open[i] = 1; m_tmr[i] = a[12] ? 4 : 2; end
        if (code == 3'd4 && (i == int'(b) || a[10])) begin m_open[i] = 0; m_tmr[i] = 0; end
      end
    end
    m_cke_q = ck;
    for (int i = 0; i < 8; i++) omask[i] = m_open[i];
    if (code != 0)
      e.v = {1'b1, code, b, (code == 3'd4) && a[10], a, rw && a[10], rw && !a[12],
             row_o, pd, sr, viol, omask};
    else
      e.v = {1'b0, 3'd0, 3'd0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, pd, sr, 1'b0, omask};
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, E_NOP, 3'd0, 16'h0, tag);
  endtask

  // monitor: one result per driven cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        logic [52:0] act;
        e   = sb.pop_front();
        act = pack_dut();
        n_chk++;
        if (act !== e.v) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = '0; m_tmr[i] = 0; end
    repeat (3) @(negedge clk);
    n_chk++;
    if (pack_dut() !== 53'h0) begin
      n_fail++;
      $display("FAIL R10 reset actual=%h expected=%h", pack_dut(), 53'h0);
    end
    rst = 1'b0;
    idle(2, "R1 nop");
    cyc(1, 0, E_ACT, 3'd2, 16'h1234, "R3 act bank2");
    cyc(1, 0, E_ACT, 3'd5, 16'hBEEF, "R3 act bank5");
    cyc(1, 0, E_RD,  3'd2, 16'h1040, "R4 read full burst");
    cyc(1, 0, E_WR,  3'd5, 16'h0088, "R4 write chopped");
    cyc(1, 0, E_ACT, 3'd2, 16'h0777, "R8 act open bank");
    cyc(1, 0, E_RD,  3'd0, 16'h1000, "R8 read closed bank");
    cyc(1, 0, E_WR,  3'd7, 16'h0000, "R8 write closed bank");
    cyc(1, 0, E_REF, 3'd0, 16'h0000, "R9 refresh while open");
    cyc(1, 0, E_MRS, 3'd1, 16'h0123, "R9 mode set while open");
    cyc(1, 1, E_ACT, 3'd0, 16'h4444, "R2 deselected act");
    cyc(1, 0, E_RD,  3'd0, 16'h1000, "R2 bank0 still closed");
    cyc(1, 0, E_PRE, 3'd5, 16'h0000, "R6 single precharge");
    cyc(1, 0, E_RD,  3'd2, 16'h1400, "R5 read autopre full");
    cyc(1, 1, E_NOP, 3'd0, 16'h0000, "R2 timer runs deselected");
    cyc(1, 1, E_PRE, 3'd2, 16'h0000, "R2 deselected precharge");
    idle(3, "R5 full window");
    cyc(1, 0, E_ACT, 3'd3, 16'h00A5, "R3 act bank3");
    cyc(1, 0, E_WR,  3'd3, 16'h0410, "R5 write autopre chop");
    idle(3, "R5 chop window");
    cyc(1, 0, E_ACT, 3'd1, 16'h0101, "R3 act bank1");
    cyc(1, 0, E_ACT, 3'd6, 16'hF00F, "R3 act bank6");
    cyc(1, 0, E_PRE, 3'd0, 16'h0400, "R6 precharge all");
    cyc(1, 0, E_REF, 3'd0, 16'h0000, "R1 refresh legal");
    cyc(1, 0, E_ZQ,  3'd0, 16'h0400, "R1 zq");
    cyc(1, 0, E_MRS, 3'd2, 16'h0A5A, "R1 mode set legal");
    cyc(0, 0, E_NOP, 3'd0, 16'h0000, "R7 power-down entry");
    cyc(0, 0, E_ACT, 3'd4, 16'h2222, "R7 cke low ignored");
    cyc(1, 0, E_NOP, 3'd0, 16'h0000, "R7 exit");
    cyc(0, 0, E_REF, 3'd0, 16'h0000, "R7 self-refresh entry");
    cyc(0, 1, E_NOP, 3'd0, 16'h0000, "R7 stay low");
    cyc(1, 1, E_NOP, 3'd0, 16'h0000, "R7 exit again");
    cyc(1, 0, E_ACT, 3'd4, 16'h3333, "R3 act after exit");
    cyc(1, 0, E_RD,  3'd4, 16'h1008, "R4 row readback");
    idle(2, "R1 tail");
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule